// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers thirty-two interrupt sources into a single request line for one CPU. Most sources are level-sensitive, so their status bit tracks the input. A fixed bit map marks the others as edge-latched: these capture a rising transition and hold it until software clears it. Three status positions are not wired to direct sources. They carry the group summaries of a secondary aggregator, which is how the two levels of the hierarchy meet.

Software sees a small register port. It can read the status word, the enable mask, the edge-latch word and a software-interrupt register. It can write the mask, the latch word and the software-interrupt register. The pending word is status AND mask. When that word is nonzero the request output is raised, and the lowest-numbered pending source is reported as a 5-bit index with a valid flag.

Every source input passes through a two-stage synchronizer before it reaches status or edge detection.

Top module: `irq_stat_ctrl`

## Requirements
- R1: After reset, the mask, the edge-latch word and the software-interrupt register all read zero, and `irq_o` and `idx_vld_o` are low.
- R2: A level-sensitive status bit follows its input, and the change is visible two clock edges after the input changes.
- R3: The edge-latched bits are 16–19, 22–24 and 28–30. Each sets on a 0-to-1 transition of its synchronized input, and is visible three clock edges after the input rises. It stays set after the input falls, and a falling input never sets it.
- R4: A write to the latch word (`addr_i`=2) clears every edge-latched bit whose written data bit is 0. A written 1 leaves the bit unchanged and cannot set it. Level-sensitive positions always read 0 in the latch word.
- R5: If a new rising edge is detected in the same cycle as a write that clears that bit, the edge wins and the bit stays set.
- R6: Status bit 4 carries group C (`grp_sum_i[2]`), bit 5 carries group B (`grp_sum_i[1]`) and bit 6 carries group A (`grp_sum_i[0]`). Bits 4–6 of `src_i` are ignored.
- R7: `irq_o` is high exactly when status AND mask is nonzero. A source whose mask bit is 0 never raises it.
- R8: `idx_o` gives the lowest-numbered set bit of status AND mask, and `idx_vld_o` is high exactly when that word is nonzero. When nothing is pending, `idx_o` reads 0.
- R9: A write to the software-interrupt register (`addr_i`=3) ORs data bits 28–30 into the latch word and ignores every other data bit. The register reads back the last written value of bits 28–30, with all other bits at 0.
- R10: The register map is status at `addr_i`=0, mask at 1, latch word at 2 and software-interrupt register at 3. Status is read-only, so writes to address 0 change nothing. The mask reads back as written, and a mask write takes effect one clock edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Raw direct sources; bits 4–6 unused |
| grp_sum_i | input | 3 | Secondary aggregator summaries: [0]=A, [1]=B, [2]=C |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the CPU |
| idx_o | output | 5 | Lowest pending enabled source |
| idx_vld_o | output | 1 | `idx_o` is meaningful |

## Verification
The checks are built on the block's latency from each kind of stimulus:
- A level input reaches status after two clock edges, because of the synchronizer.
- An edge-latched bit appears after three clock edges: one more for the edge-detect register.
- Register writes take effect at the first edge after the strobe.
- `irq_o`, `idx_o` and `rd_data_o` are combinational from the registered state.

The bench drives inputs on the falling edge and counts rising edges before it samples. It also samples one edge early to confirm that a result has not appeared before it is due. The edge-versus-clear race is built by timing the clearing write to fall in the exact cycle in which the edge detector fires.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SEL_STAT  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_LATCH = 2'd2,
    SEL_SOFT  = 2'd3
  } reg_sel_e;

  localparam logic [31:0] EDGE_MAP_DFLT = 32'h71CF_0000;
  localparam logic [31:0] SOFT_MAP_DFLT = 32'h7000_0000;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q[0] <= '0;
    else         pipe_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else         pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
  parameter int          W        = 32,
  parameter logic [31:0] EDGE_MAP = 32'h71CF_0000
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  input  logic         set_we_i,
  input  logic [W-1:0] set_data_i,
  output logic [W-1:0] latch_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (EDGE_MAP[i]) begin : g_edge
      logic prev_q, lat_q, rise;
      assign rise = lvl_i[i] & ~prev_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          lat_q  <= 1'b0;
        end else begin
          prev_q <= lvl_i[i];
          // new edge beats a clearing write
          lat_q  <= (lat_q & ~(clr_we_i & ~clr_data_i[i])) | rise
                  | (set_we_i & set_data_i[i]);
        end
      end
      assign latch_o[i] = lat_q;
    end else begin : g_lvl
      assign latch_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             vld_o
);
  always_comb begin
    idx_o = '0;
    vld_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        vld_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_pkg::*;
#(
  parameter int          NUM_SRC     = 32,
  parameter int          SYNC_STAGES = 2,
  parameter int          NUM_GRP     = 3,
  parameter int          CASC_LSB    = 4,
  parameter logic [31:0] EDGE_MAP    = EDGE_MAP_DFLT,
  parameter logic [31:0] SOFT_MAP    = SOFT_MAP_DFLT,
  localparam int         IDX_W       = $clog2(NUM_SRC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_GRP-1:0] grp_sum_i,
  input  logic [1:0]         addr_i,
  input  logic               wr_en_i,
  input  logic [NUM_SRC-1:0] wr_data_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  output logic               irq_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic               idx_vld_o
);
  localparam logic [NUM_SRC-1:0] EDGE_M = EDGE_MAP[NUM_SRC-1:0];
  localparam logic [NUM_SRC-1:0] SOFT_M = SOFT_MAP[NUM_SRC-1:0];

  logic [NUM_SRC-1:0] raw, sync_lvl, latch, status, pend;
  logic [NUM_SRC-1:0] mask_q, soft_q;
  logic               we_mask, we_latch, we_soft;

  // cascade summaries replace direct sources; group order is reversed
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_raw
    if (i >= CASC_LSB && i < CASC_LSB + NUM_GRP) begin : g_casc
      assign raw[i] = grp_sum_i[NUM_GRP-1-(i-CASC_LSB)];
    end else begin : g_dir
      assign raw[i] = src_i[i];
    end
  end

  irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (sync_lvl)
  );

  assign we_mask  = wr_en_i && (addr_i == SEL_MASK);
  assign we_latch = wr_en_i && (addr_i == SEL_LATCH);
  assign we_soft  = wr_en_i && (addr_i == SEL_SOFT);

  irq_edge_latch #(.W(NUM_SRC), .EDGE_MAP(EDGE_MAP)) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lvl_i     (sync_lvl),
    .clr_we_i  (we_latch),
    .clr_data_i(wr_data_i),
    .set_we_i  (we_soft),
    .set_data_i(wr_data_i & SOFT_M),
    .latch_o   (latch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      soft_q <= '0;
    end else begin
      if (we_mask) mask_q <= wr_data_i;
      if (we_soft) soft_q <= wr_data_i & SOFT_M;
    end
  end

  assign status = (sync_lvl & ~EDGE_M) | latch;
  assign pend   = status & mask_q;
  assign irq_o  = |pend;

  irq_prio_enc #(.W(NUM_SRC), .IDX_W(IDX_W)) u_enc (
    .req_i(pend),
    .idx_o(idx_o),
    .vld_o(idx_vld_o)
  );

  always_comb begin
    unique case (reg_sel_e'(addr_i))
      SEL_STAT:  rd_data_o = status;
      SEL_MASK:  rd_data_o = mask_q;
      SEL_LATCH: rd_data_o = latch;
      default:   rd_data_o = soft_q;
    endcase
  end
endmodule

// File: rtl/irq_stat_ctrl_chk.sv
module irq_stat_ctrl_chk #(
  parameter int NUM_SRC = 32,
  parameter int IDX_W   = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wr_en_i,
  input logic [1:0]         addr_i,
  input logic [NUM_SRC-1:0] pend,
  input logic [NUM_SRC-1:0] latch,
  input logic [NUM_SRC-1:0] mask_q,
  input logic               irq_o,
  input logic [IDX_W-1:0]   idx_o,
  input logic               idx_vld_o
);
  // R8
  idx_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_vld_o |-> pend[idx_o]);
  // R8
  idx_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_vld_o |-> ((pend & ((NUM_SRC'(1) << idx_o) - NUM_SRC'(1))) == '0));
  // R7
  irq_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == idx_vld_o);
  // R3
  latch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd2) |=> (($past(latch) & ~latch) == '0));
  // R10
  mask_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd1) |=> $stable(mask_q));
endmodule

bind irq_stat_ctrl irq_stat_ctrl_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .pend     (pend),
  .latch    (latch),
  .mask_q   (mask_q),
  .irq_o    (irq_o),
  .idx_o    (idx_o),
  .idx_vld_o(idx_vld_o)
);

// File: tb/sim_irq_stat_ctrl.sv
`timescale 1ns/1ps
module sim_irq_stat_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic [2:0]  grp = '0;
  logic [1:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic [4:0]  idx;
  logic        vld;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_stat_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .grp_sum_i(grp),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .irq_o(irq), .idx_o(idx), .idx_vld_o(vld)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd1, v); check("R1 mask", v, 0);
    rd(2'd2, v); check("R1 latch", v, 0);
    rd(2'd3, v); check("R1 soft", v, 0);
    check("R1 irq", irq, 0);
    check("R1 vld", vld, 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    src[0] = 1; src[10] = 1;
    tick();
    rd(2'd0, v); check("R2 early", v, 0);
    tick();
    rd(2'd0, v); check("R2 level on", v, 32'h0000_0401);
    src[0] = 0;
    tick(2);
    rd(2'd0, v); check("R2 level off", v, 32'h0000_0400);
    src[10] = 0;
    tick(2);
  endtask

  task automatic t_edge();
    logic [31:0] v;
    src[16] = 1;
    tick(2);
    rd(2'd0, v); check("R3 early", v[16], 0);
    tick();
    rd(2'd0, v); check("R3 latched", v[16], 1);
    src[16] = 0;
    tick(4);
    rd(2'd0, v); check("R3 held", v[16], 1);
    rd(2'd2, v); check("R3 latch word", v, 32'h0001_0000);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    src[3] = 1;
    tick(2);
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R4 ones keep", v, 32'h0001_0000);
    wr(2'd2, ~32'h0001_0000);
    rd(2'd2, v); check("R4 cleared", v, 0);
    rd(2'd0, v); check("R4 level untouched", v, 32'h0000_0008);
    src[3] = 0;
    tick(2);
  endtask

  task automatic t_race();
    logic [31:0] v;
    src[17] = 1;
    tick(2);
    addr = 2'd2; wr_data = 32'h0; wr_en = 1'b1;
    tick();
    wr_en = 1'b0;
    rd(2'd2, v); check("R5 edge wins", v[17], 1);
    src[17] = 0;
    tick(3);
    wr(2'd2, 32'h0);
    rd(2'd2, v); check("R5 then clears", v, 0);
  endtask

  task automatic t_cascade();
    logic [31:0] v;
    src[6:4] = 3'b111;
    tick(3);
    rd(2'd0, v); check("R6 direct ignored", v, 0);
    src[6:4] = 3'b000;
    grp = 3'b001;
    tick(2);
    rd(2'd0, v); check("R6 group A bit6", v, 32'h0000_0040);
    grp = 3'b100;
    tick(2);
    rd(2'd0, v); check("R6 group C bit4", v, 32'h0000_0010);
    grp = 3'b000;
    tick(2);
  endtask

  task automatic t_mask_irq();
    src[10] = 1; grp = 3'b010;
    tick(2);
    check("R7 masked irq", irq, 0);
    check("R8 masked vld", vld, 0);
    wr(2'd1, 32'h0000_0400);
    check("R7 irq on", irq, 1);
    check("R8 idx 10", idx, 10);
    wr(2'd1, 32'h0000_0420);
    check("R8 idx lowest 5", idx, 5);
    wr(2'd1, 32'h8000_0001);
    check("R7 irq off", irq, 0);
    check("R8 idx zero", {vld, 3'b0, idx}, 0);
    wr(2'd1, 0);
    src[10] = 0; grp = 0;
    tick(2);
  endtask

  task automatic t_soft();
    logic [31:0] v;
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd2, v); check("R9 soft to latch", v, 32'h7000_0000);
    rd(2'd3, v); check("R9 soft readback", v, 32'h7000_0000);
    wr(2'd1, 32'h2000_0000);
    check("R9 idx 29", idx, 29);
    wr(2'd2, 0);
    rd(2'd2, v); check("R9 cleared", v, 0);
    wr(2'd1, 0);
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); check("R10 status ro", v, 0);
    rd(2'd1, v); check("R10 mask untouched", v, 0);
    rd(2'd2, v); check("R10 latch untouched", v, 0);
    wr(2'd1, 32'hA5A5_5A5A);
    rd(2'd1, v); check("R10 mask rb", v, 32'hA5A5_5A5A);
    wr(2'd1, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_level();
    t_edge();
    t_clear();
    t_race();
    t_cascade();
    t_mask_irq();
    t_soft();
    t_regmap();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule